// File: doc/BRIEF.md
# Receive Packet Length Limiter

This block sits in the receive path between the stage that picks a destination channel and the stage that writes a channel's buffer. It forwards each data byte of a packet and counts the bytes it has forwarded against a programmable maximum length. The address and protocol bytes count as ordinary data bytes. Once that limit is reached, every further byte of the same packet is accepted and thrown away until the packet's end marker arrives.

The end marker is never forwarded. One cycle after the marker is accepted, the block pulses a status word. The word carries the number of bytes forwarded, a flag saying the packet was cut short, and a flag saying the packet closed with an error end rather than a normal end. The limit register ignores its two low bits, so the effective limit is always a multiple of four. If the effective limit is zero, the block raises a configuration-error output.

Top module: `rx_len_limiter`

## Requirements
- R1: While fewer than the effective limit of bytes of the current packet have been forwarded, each data byte (a beat with `in_end`=0) appears on `out_data` unchanged and in order.
- R2: A beat with `in_end`=1 is an end marker: it is never presented on the output stream, and `in_ready` is 1 for it.
- R3: Once the effective limit of bytes has been forwarded, further data bytes of that packet are discarded with `out_valid`=0 and `in_ready`=1, whatever the state of `out_ready`.
- R4: `stat_trunc` is 1 exactly when at least one byte of the packet was discarded. A packet whose length equals the limit is not flagged.
- R5: `stat_valid` is a one-cycle pulse in the cycle after an end marker is accepted, and at no other time.
- R6: `stat_len` equals the number of bytes the packet forwarded, that is min(packet length, effective limit).
- R7: `stat_eep` equals `in_err` of the accepted end marker (1 = error end, 0 = normal end).
- R8: `cfg_err` is 1 exactly when the effective limit is zero. In that state every data byte is discarded.
- R9: Bits [1:0] of `max_len` are ignored; the effective limit is `max_len` with those two bits cleared.
- R10: While a byte within the limit is offered and `out_ready` is 0, `in_ready` is 0, so no byte is lost.
- R11: The byte count and the truncation flag restart at zero for each packet after an end marker.
- R12: During reset, `stat_valid` is 0 and the byte count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Data byte |
| in_end | input | 1 | Beat is an end marker |
| in_err | input | 1 | End marker is an error end |
| out_valid | output | 1 | Forwarded byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Forwarded byte |
| max_len | input | 25 | Maximum packet length in bytes |
| cfg_err | output | 1 | Effective limit is zero |
| stat_valid | output | 1 | Status word valid pulse |
| stat_len | output | 25 | Bytes forwarded for the packet |
| stat_trunc | output | 1 | Packet was truncated |
| stat_eep | output | 1 | Packet closed with an error end |

## Verification
The packets exercised sit below the limit, exactly at the limit, one byte past it, and far past it. Packets just below, at and just past the limit pin the inclusive comparison down to a single byte. A limit whose two low bits are set shows whether those bits are masked. A limit of zero or three shows whether the configuration error is raised and whether every byte is dropped. Stalling `out_ready` during the forwarding phase and during the dropping phase separates the lossless back-pressure from the full-rate drain. Back-to-back packets, an empty packet and error-ended packets show the per-packet counter restart and the end-kind flag.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int unsigned RXL_LEN_W  = 25;
  localparam int unsigned RXL_BYTE_W = 8;
  localparam int unsigned RXL_GRAN_B = 2;

  typedef enum logic {
    RXL_PASS = 1'b0,
    RXL_DROP = 1'b1
  } rxl_mode_e;
endpackage

// File: rtl/rxl_limit_cfg.sv
module rxl_limit_cfg #(
  parameter int unsigned LEN_W  = rxl_pkg::RXL_LEN_W,
  parameter int unsigned GRAN_B = rxl_pkg::RXL_GRAN_B
) (
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] lim,
  output logic             cfg_err
);
  generate
    if (GRAN_B > 0) begin : g_mask
      assign lim = {max_len[LEN_W-1:GRAN_B], {GRAN_B{1'b0}}};
    end else begin : g_plain
      assign lim = max_len;
    end
  endgenerate

  assign cfg_err = (lim == '0);
endmodule

// File: rtl/rxl_route.sv
module rxl_route
  import rxl_pkg::*;
(
  input  logic in_valid,
  input  logic in_end,
  input  logic full,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic take_byte,
  output logic drop_byte,
  output logic take_mark
);
  rxl_mode_e mode;

  always_comb begin
    mode      = full ? RXL_DROP : RXL_PASS;
    out_valid = 1'b0;
    in_ready  = 1'b1;
    take_byte = 1'b0;
    drop_byte = 1'b0;
    take_mark = in_valid & in_end;
    if (!in_end) begin
      unique case (mode)
        RXL_PASS: begin
          out_valid = in_valid;
          in_ready  = out_ready;
          take_byte = in_valid & out_ready;
        end
        RXL_DROP: begin
          drop_byte = in_valid;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxl_byte_count.sv
module rxl_byte_count #(
  parameter int unsigned LEN_W = rxl_pkg::RXL_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             drop,
  input  logic             clr,
  input  logic [LEN_W-1:0] lim,
  output logic [LEN_W-1:0] cnt_q,
  output logic             trunc_q,
  output logic             full
);
  logic [LEN_W-1:0] cnt_d;
  logic             trunc_d;
  logic             cnt_en;
  logic             trunc_en;

  always_comb begin
    cnt_en   = clr | inc;
    trunc_en = clr | drop;
    cnt_d    = clr ? '0 : cnt_q + {{(LEN_W-1){1'b0}}, 1'b1};
    trunc_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q   <= cnt_d;
      if (trunc_en) trunc_q <= trunc_d;
    end
  end

  assign full = (cnt_q >= lim);
endmodule

// File: rtl/rxl_status.sv
module rxl_status #(
  parameter int unsigned LEN_W = rxl_pkg::RXL_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             trunc_in,
  input  logic             eep_in,
  output logic             stat_valid,
  output logic [LEN_W-1:0] stat_len,
  output logic             stat_trunc,
  output logic             stat_eep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_len   <= '0;
      stat_trunc <= 1'b0;
      stat_eep   <= 1'b0;
    end else begin
      stat_valid <= load;
      if (load) begin
        stat_len   <= len_in;
        stat_trunc <= trunc_in;
        stat_eep   <= eep_in;
      end
    end
  end
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter #(
  parameter int unsigned LEN_W  = rxl_pkg::RXL_LEN_W,
  parameter int unsigned BYTE_W = rxl_pkg::RXL_BYTE_W,
  parameter int unsigned GRAN_B = rxl_pkg::RXL_GRAN_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_end,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  input  logic [LEN_W-1:0]  max_len,
  output logic              cfg_err,
  output logic              stat_valid,
  output logic [LEN_W-1:0]  stat_len,
  output logic              stat_trunc,
  output logic              stat_eep
);
  logic [LEN_W-1:0] lim;
  logic [LEN_W-1:0] cnt_q;
  logic             trunc_q;
  logic             full;
  logic             take_byte;
  logic             drop_byte;
  logic             take_mark;

  rxl_limit_cfg #(.LEN_W(LEN_W), .GRAN_B(GRAN_B)) u_cfg (
    .max_len (max_len),
    .lim     (lim),
    .cfg_err (cfg_err)
  );

  rxl_route u_route (
    .in_valid  (in_valid),
    .in_end    (in_end),
    .full      (full),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .take_byte (take_byte),
    .drop_byte (drop_byte),
    .take_mark (take_mark)
  );

  rxl_byte_count #(.LEN_W(LEN_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (take_byte),
    .drop    (drop_byte),
    .clr     (take_mark),
    .lim     (lim),
    .cnt_q   (cnt_q),
    .trunc_q (trunc_q),
    .full    (full)
  );

  rxl_status #(.LEN_W(LEN_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take_mark),
    .len_in     (cnt_q),
    .trunc_in   (trunc_q),
    .eep_in     (in_err),
    .stat_valid (stat_valid),
    .stat_len   (stat_len),
    .stat_trunc (stat_trunc),
    .stat_eep   (stat_eep)
  );

  assign out_data = in_data;
endmodule

// File: rtl/rxl_checker.sv
module rxl_checker #(
  parameter int unsigned LEN_W = rxl_pkg::RXL_LEN_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_end,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             stat_valid,
  input logic [LEN_W-1:0] cnt_q
);
  // R2
  mark_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end) |-> (!out_valid && in_ready));

  // R5
  stat_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end && in_ready) |=> stat_valid);

  // R5
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_end && in_ready));

  // R3
  drop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_end && !out_valid) |-> in_ready);

  // R10
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end) |=> (cnt_q == '0));
endmodule

bind rx_len_limiter rxl_checker #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_end     (in_end),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .stat_valid (stat_valid),
  .cnt_q      (cnt_q)
);

// File: tb/sim_rx_len_limiter.sv
module sim_rx_len_limiter;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_end;
  logic        in_err;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic [24:0] max_len;
  logic        cfg_err;
  logic        stat_valid;
  logic [24:0] stat_len;
  logic        stat_trunc;
  logic        stat_eep;

  int          n_run;
  int          n_fail;
  logic        stall_en;
  logic [7:0]  lfsr;
  logic        done;
  logic [7:0]  exp_b[$];
  logic [26:0] exp_s[$];

  rx_len_limiter u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // out_ready pattern generator
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= 8'h5a;
      out_ready <= 1'b1;
    end else begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_b.size() == 0) chk(1'b0, "R1 unexpected byte", out_data, -1);
        else begin
          logic [7:0] e;
          e = exp_b.pop_front();
          chk(out_data == e, "R1 byte", out_data, e);
        end
      end
      if (stat_valid) begin
        if (exp_s.size() == 0) chk(1'b0, "R5 unexpected status", stat_len, -1);
        else begin
          logic [26:0] s;
          s = exp_s.pop_front();
          chk(stat_len == s[26:2], "R6 stat_len", stat_len, s[26:2]);
          chk(stat_trunc == s[1], "R4 stat_trunc", stat_trunc, s[1]);
          chk(stat_eep == s[0], "R7 stat_eep", stat_eep, s[0]);
        end
      end
    end
  end

  task automatic beat(input logic [7:0] d, input bit is_end, input bit err, input bit exp_pass);
    in_valid = 1'b1;
    in_data  = d;
    in_end   = is_end;
    in_err   = err;
    forever begin
      @(negedge clk);
      if (!is_end && exp_pass && !out_ready)
        chk(in_ready == 1'b0, "R10 stall holds input", in_ready, 0);
      if (!is_end && !exp_pass)
        chk(in_ready && !out_valid, "R3 drop at full rate", {in_ready, out_valid}, 2);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_end   = 1'b0;
  endtask

  task automatic send_pkt(input int n, input bit eep, input logic [24:0] mx,
                          input bit stall, input logic [7:0] base);
    int lim;
    int kept;
    max_len  = mx;
    stall_en = stall;
    lim      = int'({mx[24:2], 2'b00});
    kept     = (n < lim) ? n : lim;
    for (int i = 0; i < n; i++) begin
      if (i < lim) exp_b.push_back(base + 8'(i));
      beat(base + 8'(i), 1'b0, 1'b0, i < lim);
    end
    exp_s.push_back({25'(kept), n > lim, eep});
    beat(8'h00, 1'b1, eep, 1'b0);
  endtask

  initial begin
    n_run    = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_end   = 1'b0;
    in_err   = 1'b0;
    max_len  = 25'd64;
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(stat_valid == 1'b0, "R12 stat_valid in reset", stat_valid, 0);
    chk(out_valid == 1'b0, "R12 out_valid in reset", out_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    send_pkt(10, 1'b0, 25'd64, 1'b0, 8'h10);  // R1 R6 short packet
    send_pkt(64, 1'b0, 25'd64, 1'b1, 8'h40);  // R4 exact limit, stalls
    send_pkt(65, 1'b0, 25'd64, 1'b0, 8'h80);  // R4 one past
    send_pkt(100, 1'b1, 25'd16, 1'b1, 8'h20); // R3 R7 R10 far past
    send_pkt(20, 1'b0, 25'd19, 1'b0, 8'h30);  // R9 low bits ignored
    chk(cfg_err == 1'b0, "R9 cfg_err with 19", cfg_err, 0);
    send_pkt(1, 1'b1, 25'd4, 1'b0, 8'h50);    // R6 smallest limit
    send_pkt(0, 1'b0, 25'd8, 1'b0, 8'h00);    // R6 empty packet
    send_pkt(9, 1'b0, 25'd8, 1'b0, 8'h60);    // R11 back to back
    send_pkt(5, 1'b0, 25'd8, 1'b0, 8'h70);    // R11 restart
    max_len = 25'd0; #1;
    chk(cfg_err == 1'b1, "R8 cfg_err at zero", cfg_err, 1);
    send_pkt(3, 1'b0, 25'd0, 1'b1, 8'h90);    // R8 all dropped
    max_len = 25'd3; #1;
    chk(cfg_err == 1'b1, "R8 R9 cfg_err at three", cfg_err, 1);
    send_pkt(2, 1'b1, 25'd3, 1'b0, 8'ha0);    // R8 all dropped
    max_len = 25'd33554428; #1;
    chk(cfg_err == 1'b0, "R8 cfg_err at max", cfg_err, 0);
    send_pkt(12, 1'b0, 25'd33554428, 1'b1, 8'hb0);

    repeat (4) @(posedge clk);
    #1;
    chk(exp_b.size() == 0, "R10 no byte lost", exp_b.size(), 0);
    chk(exp_s.size() == 0, "R5 every status seen", exp_s.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule